// File: doc/BRIEF.md
# Console Manual Store Word Generator

This block turns a set of operator console switches into one storage write. Thirty-two data switches supply four bytes. Each byte is given its own parity bit, which produces a 36-bit word. A 24-bit address switch value and a four-position area selector say where the word goes. When a store request pulse arrives, the block captures the word, the address and a one-hot area enable in registers. It holds them there and raises a valid strobe for exactly one cycle, so the storage interface can perform the write.

The operator may change the switches at any moment without effect on the processor: the block reads them only in the cycle a request is accepted. A reverse-parity switch inverts the parity of all four bytes at once so that a bad word can be written for fault injection. The same switch lights the test lamp. A separate master check output is lit whenever any bit of the error register is set.

A small sequencer has two states, `ST_IDLE` and `ST_SHOW`, and three transitions:
- `ST_IDLE` moves to `ST_SHOW` on a request.
- `ST_SHOW` stays in `ST_SHOW` when a request arrives back to back.
- `ST_SHOW` returns to `ST_IDLE` when no request is present.

The valid strobe is high exactly while the sequencer is in `ST_SHOW`.

Top module: `mstore_word_gen`

## Requirements
- R1: Byte group g (g = 0..3) occupies word bits 9g+8 down to 9g. Bit 9g is the parity bit, and bits 9g+8..9g+1 carry data_keys[8g+7:8g]. The parity bits therefore sit at positions 0, 9, 18 and 27.
- R2: With rev_parity low, every 9-bit group of a stored word has odd parity, meaning it holds an odd number of ones.
- R3: With rev_parity high at the request, every one of the four parity bits is the inverse of its R2 value, so each group holds an even number of ones.
- R4: test_light equals rev_parity combinationally at all times.
- R5: After a request, area_en has exactly one bit set, namely bit area_sel. The encoding is 0 = local, 1 = main, 2 = protect, 3 = multiplexer bump storage.
- R6: After a request, store_addr equals the addr_keys value present in the request cycle.
- R7: Changes on data_keys, rev_parity, addr_keys and area_sel with store_req low leave store_word, store_addr and area_en unchanged.
- R8: store_valid is high in the cycle after each cycle with store_req high, and low otherwise. The registered outputs change only on that edge.
- R9: master_check is the OR of all bits of err_reg, combinationally.
- R10: After reset, store_word, store_addr, area_en and store_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| data_keys | input | 32 | Data switch value, four bytes |
| rev_parity | input | 1 | Reverse-parity switch |
| addr_keys | input | 24 | Address switch value |
| area_sel | input | 2 | Storage area selector |
| store_req | input | 1 | Single-cycle store request |
| err_reg | input | 8 | Error register bits |
| store_word | output | 36 | Captured word with parity |
| area_en | output | 4 | One-hot storage area enable |
| store_addr | output | 24 | Captured address |
| store_valid | output | 1 | One-cycle strobe for the captured store |
| test_light | output | 1 | Test lamp drive |
| master_check | output | 1 | Master check lamp drive |

## Verification
Every byte value from 0 to 255 is stored in both parity modes. Each lane receives a different transform of the value (identity, complement, XOR with 5A, plus 37), so a lane swap, a wrong parity position or a parity sense error in any single lane gives a mismatch. All four selector positions and walking-one address patterns separate decode and bit-order faults. Switch changes without a request show whether the block samples early or leaks inputs through. A full sweep of the error register checks the reduction OR against a single-bit fault.

// File: rtl/mstore_pkg.sv
package mstore_pkg;
    localparam int LANE_DATA_W = 8;
    localparam int LANE_W      = LANE_DATA_W + 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } seq_state_t;
endpackage

// File: rtl/mstore_parity_lane.sv
module mstore_parity_lane
    import mstore_pkg::*;
(
    input  logic [LANE_DATA_W-1:0] byte_in,
    input  logic                   invert,
    output logic [LANE_W-1:0]      lane_out
);
    logic odd_bit;

    // Parity bit makes the 9-bit group odd, optionally inverted.
    always_comb begin
        odd_bit  = ~(^byte_in) ^ invert;
        lane_out = {byte_in, odd_bit};
    end
endmodule

// File: rtl/mstore_area_decode.sv
module mstore_area_decode #(
    parameter int SEL_W = 2,
    localparam int AREA_N = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]  sel,
    output logic [AREA_N-1:0] enables
);
    for (genvar i = 0; i < AREA_N; i++) begin : g_dec
        assign enables[i] = (sel == SEL_W'(i));
    end
endmodule

// File: rtl/mstore_seq.sv
module mstore_seq
    import mstore_pkg::*;
#(
    parameter int WORD_W = 36,
    parameter int ADDR_W = 24,
    parameter int AREA_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [WORD_W-1:0] word_d,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [AREA_N-1:0] area_d,
    output logic [WORD_W-1:0] word_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [AREA_N-1:0] area_q,
    output logic              valid
);
    seq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req) state_nx = ST_SHOW;
            ST_SHOW: state_nx = req ? ST_SHOW : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            addr_q <= '0;
            area_q <= '0;
        end else if (req) begin
            word_q <= word_d;
            addr_q <= addr_d;
            area_q <= area_d;
        end
    end

    always_comb begin
        valid = (state == ST_SHOW);
    end

    // R8: strobe follows each request by one cycle
    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> valid);
    // R8: no strobe without a request
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !valid);
    // R7: held outputs do not move without a request
    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> ($stable(word_q) && $stable(addr_q) && $stable(area_q)));
    // R6: address captured from request cycle
    a_r6_addr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> (addr_q == $past(addr_d)));
endmodule

// File: rtl/mstore_word_gen.sv
module mstore_word_gen
    import mstore_pkg::*;
#(
    parameter int N_BYTES = 4,
    parameter int ADDR_W  = 24,
    parameter int SEL_W   = 2,
    parameter int ERR_W   = 8,
    localparam int DATA_W = N_BYTES * LANE_DATA_W,
    localparam int WORD_W = N_BYTES * LANE_W,
    localparam int AREA_N = 1 << SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_keys,
    input  logic              rev_parity,
    input  logic [ADDR_W-1:0] addr_keys,
    input  logic [SEL_W-1:0]  area_sel,
    input  logic              store_req,
    input  logic [ERR_W-1:0]  err_reg,
    output logic [WORD_W-1:0] store_word,
    output logic [AREA_N-1:0] area_en,
    output logic [ADDR_W-1:0] store_addr,
    output logic              store_valid,
    output logic              test_light,
    output logic              master_check
);
    logic [WORD_W-1:0] word_d;
    logic [AREA_N-1:0] area_d;

    for (genvar g = 0; g < N_BYTES; g++) begin : g_lane
        mstore_parity_lane u_lane (
            .byte_in (data_keys[g*LANE_DATA_W +: LANE_DATA_W]),
            .invert  (rev_parity),
            .lane_out(word_d[g*LANE_W +: LANE_W])
        );
    end

    mstore_area_decode #(.SEL_W(SEL_W)) u_dec (
        .sel    (area_sel),
        .enables(area_d)
    );

    mstore_seq #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W),
        .AREA_N(AREA_N)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (store_req),
        .word_d(word_d),
        .addr_d(addr_keys),
        .area_d(area_d),
        .word_q(store_word),
        .addr_q(store_addr),
        .area_q(area_en),
        .valid (store_valid)
    );

    always_comb begin
        test_light   = rev_parity;
        master_check = |err_reg;
    end

    // R2/R3: group parity sense set by the switch in the request cycle
    for (genvar g = 0; g < N_BYTES; g++) begin : g_chk
        a_r3_group_parity: assert property (@(posedge clk) disable iff (!rst_n)
            store_req |=> ((^store_word[g*LANE_W +: LANE_W]) == !$past(rev_parity)));
    end

    // R5: one area enable per store
    a_r5_area_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        store_valid |-> ($countones(area_en) == 1));
endmodule

// File: tb/sim_mstore_word_gen.sv
`timescale 1ns/1ps
module sim_mstore_word_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_keys = '0;
    logic        rev_parity = 1'b0;
    logic [23:0] addr_keys = '0;
    logic [1:0]  area_sel = '0;
    logic        store_req = 1'b0;
    logic [7:0]  err_reg = '0;
    logic [35:0] store_word;
    logic [3:0]  area_en;
    logic [23:0] store_addr;
    logic        store_valid, test_light, master_check;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mstore_word_gen u0 (
        .clk(clk), .rst_n(rst_n), .data_keys(data_keys), .rev_parity(rev_parity),
        .addr_keys(addr_keys), .area_sel(area_sel), .store_req(store_req),
        .err_reg(err_reg), .store_word(store_word), .area_en(area_en),
        .store_addr(store_addr), .store_valid(store_valid),
        .test_light(test_light), .master_check(master_check)
    );

    function automatic logic [35:0] exp_word(input logic [31:0] k, input logic rv);
        logic [35:0] w;
        for (int g = 0; g < 4; g++) begin
            logic [7:0] b;
            b = k[g*8 +: 8];
            w[g*9] = ~(^b) ^ rv;
            w[g*9+1 +: 8] = b;
        end
        return w;
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_store();
        @(negedge clk);
        store_req = 1'b1;
        @(negedge clk);
        store_req = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", {store_word, store_addr, area_en, store_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", {store_word, store_addr, area_en, store_valid}, '0);

        // R1 R2 R3: all byte values, both parity senses
        for (int rv = 0; rv < 2; rv++) begin
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                b = 8'(v);
                data_keys  = {b + 8'd37, b ^ 8'h5A, ~b, b};
                rev_parity = 1'(rv);
                do_store();
                check(rv ? "R3" : "R1/R2", store_word, exp_word(data_keys, 1'(rv)));
                check("R8", 36'(store_valid), 36'd1);
            end
        end

        // R4: test light follows switch
        for (int t = 0; t < 2; t++) begin
            @(negedge clk);
            rev_parity = 1'(t);
            #1;
            check("R4", 36'(test_light), 36'(t));
        end

        // R5: area decode, R6: address walking ones
        for (int s = 0; s < 4; s++) begin
            area_sel = 2'(s);
            do_store();
            check("R5", 36'(area_en), 36'(4'b0001 << s));
        end
        for (int i = 0; i < 24; i++) begin
            addr_keys = 24'd1 << i;
            do_store();
            check("R6", 36'(store_addr), 36'(24'd1 << i));
        end
        addr_keys = 24'hA5C3E1;
        do_store();
        check("R6", 36'(store_addr), 36'h0A5C3E1);

        // R8: strobe drops after one cycle
        @(negedge clk);
        check("R8", 36'(store_valid), 36'd0);

        // R7: inputs change with no request, outputs held
        data_keys = 32'h1234_5678; rev_parity = 1'b0;
        addr_keys = 24'h00F00F; area_sel = 2'd2;
        do_store();
        data_keys = 32'hFFFF_0000; rev_parity = 1'b1;
        addr_keys = 24'h123456; area_sel = 2'd0;
        repeat (3) @(negedge clk);
        check("R7", store_word, exp_word(32'h1234_5678, 1'b0));
        check("R7", 36'(store_addr), 36'h000F00F);
        check("R7", 36'(area_en), 36'b0100);
        check("R7", 36'(store_valid), 36'd0);

        // R8: back-to-back requests keep strobe high
        @(negedge clk);
        store_req = 1'b1;
        @(negedge clk);
        check("R8", 36'(store_valid), 36'd1);
        @(negedge clk);
        store_req = 1'b0;
        check("R8", 36'(store_valid), 36'd1);
        @(negedge clk);
        check("R8", 36'(store_valid), 36'd0);

        // R9: master check over all error register values
        for (int e = 0; e < 256; e++) begin
            err_reg = 8'(e);
            #1;
            check("R9", 36'(master_check), 36'(e != 0));
        end

        summary();
    end
endmodule